// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block lets a host reach the management registers of external Ethernet PHYs. The host loads a set of small configuration registers with a target port, a register page, a register number, an optional extended device and address, and write data. It then sets an execute bit in the access word. The controller checks that the request is legal and builds the required management frames. It shifts them out on a divided management clock, collects read data from the PHY and clears the execute bit when it is done. An error bit then tells the host whether the transaction failed.

Two addressing schemes are supported. In paged Clause-22 mode, a write to register 31 first selects the page, and the addressed access follows. A reserved raw page value skips the page write. In Clause-45 mode, an address frame carrying the device and the 16-bit register address comes first, and a read or write frame follows. Every frame on the wire starts with 32 preamble ones.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all four configuration registers read as zero, `mdc` is low and `mdio_oe` is low.
- R2: Writing the access word (address 0) with bit 0 set while idle starts a transaction. Bit 0 then reads 1 until the last frame ends. Each frame is sent as 32 ones followed by start, opcode, 5-bit PHY address, 5-bit register or device, 2 turnaround bits and 16 data bits, most significant bit first.
- R3: Each half period of `mdc` lasts `mdc_div` system clocks, with a value of 0 treated as 1. `mdio_o` changes only while `mdc` is low.
- R4: Clause-22 access (access bit 2 = 0) first sends a write frame (start 01, opcode 01) to register 31 whose data is the page from access bits 22:10. It then sends the access frame with start 01, opcode 01 for a write (access bit 3 = 1) or 10 for a read, and the register number from access bits 9:5.
- R5: When the page field is 0x1fff and access bits 27:23 are all ones, a Clause-22 access sends only the access frame.
- R6: Clause-45 access (access bit 2 = 1) sends an address frame (start 00, opcode 00) carrying the device from bits 20:16 of the extended-address register (address 2) and the address from its bits 15:0. It then sends a frame with opcode 01 for a write or 11 for a read, to the same device.
- R7: In a read frame the controller releases `mdio_oe` from the first turnaround bit onward. The 16 bits it samples are placed in bits 15:0 of the data register (address 1), and bits 31:16 stay as they were.
- R8: For a read, the port is taken from data register bits 31:16. For a write, the port comes from target register (address 3) bits 15:0 and the write data from data register bits 31:16. The PHY address on the wire is the low 5 bits of the port.
- R9: A read whose second turnaround bit is sampled high sets access bit 1 (error). A read that completes normally clears it, and so does any write.
- R10: A start is rejected when the port is above 63, or when a Clause-22 page is above 4095 and is not the raw page of R5. A rejected start sets the error bit, leaves bit 0 clear and puts nothing on the wire.
- R11: While a transaction is in flight, host writes to any configuration register are ignored. This includes a second execute request and a write made in the cycle the transaction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_div | input | 8 | Management clock half period in system clocks (0 acts as 1) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Register select: 0 access, 1 data, 2 extended address, 3 target port |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the register selected by `cfg_addr` |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven toward the PHYs |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data received from the bus (pulled high when undriven) |

## Verification
The collision that matters is a host register write landing in the same cycle that the final frame completes. In that cycle the controller both loads the read result into the data register and clears the busy bit. The bench starts a raw read, then writes all ones to the data register on every cycle until one cycle past the last falling edge of `mdc`, so that the final write coincides with completion. It also tries a second execute mid-flight. It passes only if the data register holds the original port above the PHY's reply, the access word keeps its original register number, and exactly one frame appeared on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PORT_W    = 16;
    localparam int PAGE_W    = 13;
    localparam int FIELD_W   = 5;
    localparam int WORD_W    = 16;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int FRAME_W   = 32;
    localparam int SHIFT_W   = PRE_BITS + FRAME_W;
    localparam int IDX_W     = $clog2(SHIFT_W);

    localparam logic [PAGE_W-1:0]  PAGE_RAW   = '1;
    localparam logic [PAGE_W-1:0]  PAGE_LIMIT = 13'd4095;
    localparam logic [PORT_W-1:0]  PORT_LIMIT = 16'd63;
    localparam logic [FIELD_W-1:0] PAGE_SEL_REG = 5'd31;

    localparam logic [1:0] ADDR_ACC  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_XREG = 2'd2;
    localparam logic [1:0] ADDR_TGT  = 2'd3;

    localparam logic [1:0] ST_C22 = 2'b01;
    localparam logic [1:0] ST_C45 = 2'b00;
    localparam logic [1:0] TA_DRIVE = 2'b10;
    localparam logic [1:0] TA_FLOAT = 2'b11;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_PAGE,
        STEP_ACCESS,
        STEP_XADDR,
        STEP_XDATA
    } step_e;

    typedef struct packed {
        logic [1:0]         st;
        logic [1:0]         op;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regad;
        logic [1:0]         ta;
        logic [WORD_W-1:0]  data;
    } frame_t;

    typedef struct packed {
        logic [FIELD_W-1:0] pgx;
        logic [PAGE_W-1:0]  page;
        logic [FIELD_W-1:0] regn;
        logic               wr;
        logic               c45;
    } acc_t;

    function automatic frame_t mk_frame(input logic [1:0] st, input logic [1:0] op,
                                        input logic [FIELD_W-1:0] phy,
                                        input logic [FIELD_W-1:0] regad,
                                        input logic is_wr,
                                        input logic [WORD_W-1:0] data);
        frame_t f;
        f.st    = st;
        f.op    = op;
        f.phy   = phy;
        f.regad = regad;
        f.ta    = is_wr ? TA_DRIVE : TA_FLOAT;
        f.data  = is_wr ? data : '1;
        return f;
    endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim_m1;

    assign lim_m1 = (div == '0) ? '0 : div - 1'b1;
    assign tick   = en && (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == lim_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (en && tick && $past(en) && $past(tick)) |-> (div <= 1)) else $error("tick gap"); // R3

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  frame_t            frame,
    input  logic              is_read,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              ta_ok,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + HDR_BITS);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_BITS + HDR_BITS + 1);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_BITS + HDR_BITS + 2);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SHIFT_W - 1);

    logic [SHIFT_W-1:0] sh;
    logic [IDX_W-1:0]   bitn;
    logic               hi;
    logic               rd_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            done    <= 1'b0;
            hi      <= 1'b0;
            mdc     <= 1'b0;
            bitn    <= '0;
            sh      <= '0;
            rd_mode <= 1'b0;
            rd_data <= '0;
            ta_ok   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                hi      <= 1'b0;
                mdc     <= 1'b0;
                bitn    <= '0;
                sh      <= {{PRE_BITS{1'b1}}, frame};
                rd_mode <= is_read;
            end else if (active && tick) begin
                if (!hi) begin
                    mdc <= 1'b1;
                    hi  <= 1'b1;
                    if (rd_mode && bitn == TA2_IDX) begin
                        ta_ok <= !mdio_i;
                    end
                    if (rd_mode && bitn >= DAT_IDX) begin
                        rd_data <= {rd_data[WORD_W-2:0], mdio_i};
                    end
                end else begin
                    mdc <= 1'b0;
                    hi  <= 1'b0;
                    if (bitn == LAST_IDX) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sh   <= {sh[SHIFT_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mdio_o  = active ? sh[SHIFT_W-1] : 1'b1;
    assign mdio_oe = active && !(rd_mode && bitn >= TA_IDX);

    AST_MDIO_HELD: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o)) else $error("mdio moved while mdc high"); // R3

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !active) else $error("start while frame active"); // R11

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_rd_data,
    input  logic              eng_ta_ok,
    output logic              eng_start,
    output frame_t            eng_frame,
    output logic              eng_is_read
);

    acc_t               acc_q;
    logic               busy_q;
    logic               err_q;
    logic [31:0]        data_q;
    logic [FIELD_W-1:0] dev_q;
    logic [WORD_W-1:0]  xaddr_q;
    logic [PORT_W-1:0]  tgt_q;
    logic [FIELD_W-1:0] phy_q;
    step_e              step_q;
    logic               start_q;

    acc_t              acc_new;
    logic              go;
    logic              raw_new;
    logic              bad;
    logic              last_step;
    logic [PORT_W-1:0] port_sel;

    always_comb begin
        acc_new.pgx  = cfg_wdata[27:23];
        acc_new.page = cfg_wdata[22:10];
        acc_new.regn = cfg_wdata[9:5];
        acc_new.wr   = cfg_wdata[3];
        acc_new.c45  = cfg_wdata[2];
        go        = cfg_we && !busy_q && (cfg_addr == ADDR_ACC) && cfg_wdata[0];
        raw_new   = (acc_new.page == PAGE_RAW) && (acc_new.pgx == '1);
        port_sel  = acc_new.wr ? tgt_q : data_q[31:16];
        bad       = (port_sel > PORT_LIMIT) ||
                    (!acc_new.c45 && (acc_new.page > PAGE_LIMIT) && !raw_new);
        last_step = (step_q == STEP_ACCESS) || (step_q == STEP_XDATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            data_q  <= '0;
            dev_q   <= '0;
            xaddr_q <= '0;
            tgt_q   <= '0;
            phy_q   <= '0;
            step_q  <= STEP_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (cfg_we && !busy_q) begin
                case (cfg_addr)
                    ADDR_ACC: begin
                        acc_q <= acc_new;
                        if (cfg_wdata[0]) begin
                            if (bad) begin
                                err_q <= 1'b1;
                            end else begin
                                err_q   <= 1'b0;
                                busy_q  <= 1'b1;
                                phy_q   <= port_sel[FIELD_W-1:0];
                                start_q <= 1'b1;
                                if (acc_new.c45)  step_q <= STEP_XADDR;
                                else if (raw_new) step_q <= STEP_ACCESS;
                                else              step_q <= STEP_PAGE;
                            end
                        end
                    end
                    ADDR_DATA: data_q <= cfg_wdata;
                    ADDR_XREG: begin
                        dev_q   <= cfg_wdata[20:16];
                        xaddr_q <= cfg_wdata[15:0];
                    end
                    default:   tgt_q <= cfg_wdata[15:0];
                endcase
            end
            if (busy_q && eng_done) begin
                if (!last_step) begin
                    start_q <= 1'b1;
                    step_q  <= (step_q == STEP_PAGE) ? STEP_ACCESS : STEP_XDATA;
                end else begin
                    busy_q <= 1'b0;
                    step_q <= STEP_IDLE;
                    if (!acc_q.wr) begin
                        data_q[WORD_W-1:0] <= eng_rd_data;
                        err_q <= !eng_ta_ok;
                    end else begin
                        err_q <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        case (step_q)
            STEP_PAGE:   eng_frame = mk_frame(ST_C22, 2'b01, phy_q, PAGE_SEL_REG, 1'b1,
                                              WORD_W'(acc_q.page));
            STEP_ACCESS: eng_frame = mk_frame(ST_C22, acc_q.wr ? 2'b01 : 2'b10, phy_q,
                                              acc_q.regn, acc_q.wr, data_q[31:16]);
            STEP_XADDR:  eng_frame = mk_frame(ST_C45, 2'b00, phy_q, dev_q, 1'b1, xaddr_q);
            STEP_XDATA:  eng_frame = mk_frame(ST_C45, acc_q.wr ? 2'b01 : 2'b11, phy_q,
                                              dev_q, acc_q.wr, data_q[31:16]);
            default:     eng_frame = '0;
        endcase
        eng_is_read = !acc_q.wr && last_step;
        eng_start   = start_q;
    end

    always_comb begin
        case (cfg_addr)
            ADDR_ACC:  cfg_rdata = {4'b0, acc_q.pgx, acc_q.page, acc_q.regn, 1'b0,
                                    acc_q.wr, acc_q.c45, err_q, busy_q};
            ADDR_DATA: cfg_rdata = data_q;
            ADDR_XREG: cfg_rdata = {11'b0, dev_q, xaddr_q};
            default:   cfg_rdata = {16'b0, tgt_q};
        endcase
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !eng_done) |=> busy_q) else $error("busy dropped early"); // R2

    AST_LOCKED_DATA: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cfg_we && cfg_addr == ADDR_DATA && !eng_done) |=> $stable(data_q))
        else $error("data written while busy"); // R11

    AST_REJECT: assert property (@(posedge clk) disable iff (rst)
        (go && bad) |=> (!busy_q && err_q)) else $error("illegal request accepted"); // R10

    AST_READ_ERR: assert property (@(posedge clk) disable iff (rst)
        (busy_q && eng_done && last_step && !acc_q.wr && !eng_ta_ok) |=> err_q)
        else $error("missing read error"); // R9

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] mdc_div,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic              tick;
    logic              eng_active;
    logic              eng_done;
    logic              eng_start;
    logic              eng_is_read;
    logic              eng_ta_ok;
    logic [WORD_W-1:0] eng_rd_data;
    frame_t            eng_frame;

    mdio_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (eng_active),
        .div  (mdc_div),
        .tick (tick)
    );

    mdio_frame_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (eng_start),
        .frame   (eng_frame),
        .is_read (eng_is_read),
        .mdio_i  (mdio_i),
        .active  (eng_active),
        .done    (eng_done),
        .rd_data (eng_rd_data),
        .ta_ok   (eng_ta_ok),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mdio_host_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .eng_done    (eng_done),
        .eng_rd_data (eng_rd_data),
        .eng_ta_ok   (eng_ta_ok),
        .eng_start   (eng_start),
        .eng_frame   (eng_frame),
        .eng_is_read (eng_is_read)
    );

endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;

    localparam logic [1:0] A_ACC = 2'd0, A_DATA = 2'd1, A_XREG = 2'd2, A_TGT = 2'd3;

    typedef struct packed {
        logic        c45;
        logic        wr;
        logic [15:0] port;
        logic [12:0] page;
        logic [4:0]  pgx;
        logic [4:0]  regn;
        logic [4:0]  dev;
        logic [15:0] xaddr;
        logic [15:0] wdata;
        logic [15:0] rsp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 16'd5,  13'h003,  5'h00, 5'd2, 5'd0, 16'h0000, 16'h0000, 16'hA5C3},
        '{1'b0, 1'b1, 16'd17, 13'h123,  5'h00, 5'd9, 5'd0, 16'h0000, 16'hBEEF, 16'h0000},
        '{1'b0, 1'b0, 16'd2,  13'h1fff, 5'h1f, 5'd7, 5'd0, 16'h0000, 16'h0000, 16'h1234},
        '{1'b1, 1'b1, 16'd9,  13'h000,  5'h00, 5'd0, 5'd1, 16'h0014, 16'h8001, 16'h0000},
        '{1'b1, 1'b0, 16'd33, 13'h000,  5'h00, 5'd0, 5'd7, 16'h003C, 16'h0000, 16'h5AA5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mdc_div = 8'd2;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .mdc_div(mdc_div), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_err = 0;

    // PHY model
    logic        phy_present = 1'b1;
    logic [15:0] phy_rsp = '0;
    logic        phy_drv_en = 1'b0;
    logic        phy_drv = 1'b1;
    int          ones = 0;
    int          fpos = -1;
    int          nfr = 0;
    logic [13:0] hdr = '0;
    logic [15:0] dat = '0;
    logic        ta_oe = 1'b0;
    logic [13:0] log_hdr [4];
    logic [15:0] log_dat [4];
    logic        log_ta_oe [4];

    assign mdio_i = phy_drv_en ? phy_drv : 1'b1;

    function automatic logic is_rd_hdr(input logic [13:0] h);
        return (h[13:10] == 4'b0110) || (h[13:10] == 4'b0011);
    endfunction

    always @(posedge mdc) begin
        if (fpos < 0) begin
            if (mdio_o) ones++;
            else begin
                if (ones >= 32) begin
                    fpos = 1;
                    hdr  = '0;
                end
                ones = 0;
            end
        end else begin
            if (fpos < 14) hdr = {hdr[12:0], mdio_o};
            else if (fpos == 14) ta_oe = mdio_oe;
            else if (fpos >= 16) dat = {dat[14:0], mdio_oe ? mdio_o : mdio_i};
            if (fpos == 31) begin
                if (nfr < 4) begin
                    log_hdr[nfr]   = hdr;
                    log_dat[nfr]   = dat;
                    log_ta_oe[nfr] = ta_oe;
                end
                nfr++;
                fpos = -1;
                ones = 0;
            end else begin
                fpos++;
            end
        end
    end

    always @(negedge mdc) begin
        phy_drv_en = 1'b0;
        if (phy_present && fpos >= 15 && is_rd_hdr(hdr)) begin
            phy_drv_en = 1'b1;
            phy_drv    = (fpos == 15) ? 1'b0 : phy_rsp[31-fpos];
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] a);
        a = '1;
        for (int k = 0; k < 20000; k++) begin
            rd_reg(A_ACC, a);
            if (!a[0]) break;
        end
    endtask

    function automatic logic [31:0] acc_word(input vec_t v, input logic go);
        return {4'b0, v.pgx, v.page, v.regn, 1'b0, v.wr, v.c45, 1'b0, go};
    endfunction

    task automatic load_vec(input vec_t v);
        phy_rsp = v.rsp;
        if (v.wr) begin
            wr_reg(A_TGT, {16'b0, v.port});
            wr_reg(A_DATA, {v.wdata, 16'h0});
        end else begin
            wr_reg(A_DATA, {v.port, 16'h0});
        end
        wr_reg(A_XREG, {11'b0, v.dev, v.xaddr});
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] r;
        logic [13:0] eh [2];
        logic [15:0] ed [2];
        int          en;
        logic [4:0]  phy;
        logic        raw;
        string       rq;
        raw = (v.page == 13'h1fff) && (v.pgx == 5'h1f);
        rq  = v.c45 ? "R6" : (raw ? "R5" : "R4");
        phy = v.port[4:0];
        if (v.c45) begin
            en = 2;
            eh[0] = {2'b00, 2'b00, phy, v.dev}; ed[0] = v.xaddr;
            eh[1] = {2'b00, v.wr ? 2'b01 : 2'b11, phy, v.dev}; ed[1] = v.wr ? v.wdata : v.rsp;
        end else if (raw) begin
            en = 1;
            eh[0] = {2'b01, v.wr ? 2'b01 : 2'b10, phy, v.regn}; ed[0] = v.wr ? v.wdata : v.rsp;
            eh[1] = '0; ed[1] = '0;
        end else begin
            en = 2;
            eh[0] = {2'b01, 2'b01, phy, 5'd31}; ed[0] = {3'b0, v.page};
            eh[1] = {2'b01, v.wr ? 2'b01 : 2'b10, phy, v.regn}; ed[1] = v.wr ? v.wdata : v.rsp;
        end
        load_vec(v);
        nfr = 0;
        wr_reg(A_ACC, acc_word(v, 1'b1));
        rd_reg(A_ACC, r);
        chk("R2", "busy after start", {31'b0, r[0]}, 32'd1);
        wait_idle(r);
        chk("R2", "busy after end", {31'b0, r[0]}, 32'd0);
        chk(rq, "frame count", nfr, en);
        for (int i = 0; i < 2; i++) begin
            if (i < en) begin
                chk(rq, "frame header", {18'b0, log_hdr[i]}, {18'b0, eh[i]});
                chk(rq, "frame data", {16'b0, log_dat[i]}, {16'b0, ed[i]});
            end
        end
        chk("R8", "phy address", {27'b0, log_hdr[en-1][9:5]}, {27'b0, v.port[4:0]});
        if (!v.wr) begin
            chk("R7", "drive released at turnaround", {31'b0, log_ta_oe[en-1]}, 32'd0);
        end
        chk("R9", "error bit clear", {31'b0, r[1]}, 32'd0);
        rd_reg(A_DATA, r);
        chk("R7", "data register", r, v.wr ? {v.wdata, 16'h0} : {v.port, v.rsp});
    endtask

    task automatic half_period(input logic [7:0] dv, input int exp);
        logic [31:0] r;
        int          n;
        vec_t        v;
        v = VECS[2];
        mdc_div = dv;
        load_vec(v);
        wr_reg(A_ACC, acc_word(v, 1'b1));
        @(posedge mdc);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mdc) n++;
            else break;
        end
        chk("R3", "mdc high clocks", n, exp);
        wait_idle(r);
        mdc_div = 8'd2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        vec_t        v;
        int          falls;
        logic        pm;
        int          nb;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), r);
            chk("R1", "register after reset", r, 32'd0);
        end
        chk("R1", "mdc after reset", {31'b0, mdc}, 32'd0);
        chk("R1", "oe after reset", {31'b0, mdio_oe}, 32'd0);

        // table walk
        for (int i = 0; i < 5; i++) run_vec(VECS[i]);

        // R3 clock division
        half_period(8'd3, 3);
        half_period(8'd0, 1);

        // R9 absent PHY then recovery
        phy_present = 1'b0;
        v = VECS[2];
        load_vec(v);
        wr_reg(A_ACC, acc_word(v, 1'b1));
        wait_idle(r);
        chk("R9", "error on silent turnaround", {31'b0, r[1]}, 32'd1);
        phy_present = 1'b1;
        wr_reg(A_ACC, acc_word(v, 1'b1));
        wait_idle(r);
        chk("R9", "error cleared on good read", {31'b0, r[1]}, 32'd0);

        // R10 rejections
        v = VECS[0];
        v.port = 16'd64;
        load_vec(v);
        nb = nfr;
        wr_reg(A_ACC, acc_word(v, 1'b1));
        rd_reg(A_ACC, r);
        chk("R10", "port 64 busy", {31'b0, r[0]}, 32'd0);
        chk("R10", "port 64 error", {31'b0, r[1]}, 32'd1);
        v = VECS[0];
        v.page = 13'd4096;
        load_vec(v);
        wr_reg(A_ACC, acc_word(v, 1'b1));
        rd_reg(A_ACC, r);
        chk("R10", "page 4096 error", {30'b0, r[1:0]}, 32'd2);
        v.page = 13'h1fff;
        v.pgx  = 5'h00;
        wr_reg(A_ACC, acc_word(v, 1'b1));
        rd_reg(A_ACC, r);
        chk("R10", "raw page without flag error", {30'b0, r[1:0]}, 32'd2);
        repeat (600) @(negedge clk);
        chk("R10", "no frames after reject", nfr, nb);

        // R11 writes during flight and at completion
        mdc_div = 8'd1;
        v = VECS[2];
        load_vec(v);
        nfr = 0;
        wr_reg(A_ACC, acc_word(v, 1'b1));
        v.regn = 5'd20;
        wr_reg(A_ACC, acc_word(v, 1'b1));
        falls = 0;
        pm = mdc;
        cfg_we = 1'b1; cfg_addr = A_DATA; cfg_wdata = '1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (pm && !mdc) falls++;
            pm = mdc;
            if (falls == 64) break;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        rd_reg(A_ACC, r);
        chk("R11", "busy cleared", {31'b0, r[0]}, 32'd0);
        chk("R11", "register number kept", {27'b0, r[9:5]}, 32'd7);
        chk("R11", "single frame", nfr, 1);
        rd_reg(A_DATA, r);
        chk("R11", "data register untouched by writes", r, {VECS[2].port, VECS[2].rsp});

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule